// File: doc/BRIEF.md
# Delay-Line XOR Frequency Stabilizer Core

This core holds a free-running oscillator near one of a comb of stable frequencies. A prescaler divides the reference clock into a sample strobe. Each strobe takes a sample of the squared-up oscillator level, after it passes a two-flop synchronizer, and pushes it into a serial delay line of `N` bits. The new sample is XORed with the sample that leaves the far end of the line, which was taken `N` strobes earlier. That XOR is the single-bit correction output. An external integrator and tuning element, outside this block, turn the correction bit into a tuning voltage.

The stable frequencies are spaced by the sample rate divided by `N`. Two examples: 2400 Hz with 480 taps gives 5 Hz, and roughly 2929.6 Hz with 296 taps gives roughly 9.89 Hz. Far from a lock point the correction bit averages close to half duty. Its average swings strongly only within a small fraction of a hertz of a lock point. The division ratio is a run-time input. The strobe is also brought out so that a reference model can follow the block one sample at a time.

Top module: `xls_stabilizer`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, the block clears the prescaler count, the synchronizer and every delay-line bit. After that edge `corr_o` and `stb_o` read 0.
- R2: `stb_o` is high for one cycle in each prescaler period. A period loaded from a ratio value `D` lasts `D+1` clock cycles. The first strobe follows the first clock edge after reset.
- R3: A new ratio on `div_i` takes effect only when the current period ends. A change made in the middle of a period leaves that period's length unchanged.
- R4: At the clock edge that ends a strobe cycle, `corr_o` becomes the new sample XOR the sample taken `N` strobes earlier. Samples from before the first `N` strobes after reset count as 0.
- R5: `corr_o` changes only at the clock edge that ends a strobe cycle and holds its value otherwise.
- R6: The sample taken at a strobe is the level that `osc_i` had two clock edges before that strobe's closing edge. This is the two-flop synchronizer latency.
- R7: When `N*(D+1)` clock cycles are a whole number of oscillator periods, `corr_o` stays 0 once the first `N` strobes after reset have passed. This is a lock point.
- R8: When the oscillator period does not divide `N*(D+1)`, `corr_o` takes both values over time. This is a beat.
- R9: Any `N >= 1` is accepted, including `N = 1`, which uses a single-flop variant. The default is 296.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference and system clock |
| rst_i | input | 1 | Synchronous reset, active high |
| osc_i | input | 1 | Squared-up oscillator level, asynchronous |
| div_i | input | DIV_W | Prescaler ratio; the period is `div_i+1` cycles |
| corr_o | output | 1 | Registered correction bit |
| stb_o | output | 1 | One-cycle sample strobe |

## Verification
Embedded assertions check four properties on every cycle:
- the prescaler count never passes its latched limit;
- the latched limit changes only at an overflow;
- the correction bit holds outside strobe edges;
- reset clears both outputs.

Only the bench's scenarios can show the frequency behaviour. It compares the block against a queue-based reference model on every clock. It checks that a square wave at a lock point gives a constant zero, and that an offset period gives a beat. It also checks that a ratio change made mid-period moves the strobe only from the next period on.

// File: rtl/xls_pkg.sv
package xls_pkg;
   localparam int XLS_SYNC_STAGES = 2;
   localparam int XLS_DEF_TAPS    = 296;
   localparam int XLS_DEF_DIV_W   = 16;
endpackage

// File: rtl/xls_sync.sv
module xls_sync #(
   parameter int STAGES = xls_pkg::XLS_SYNC_STAGES
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic d_i,
   output logic q_o
);
   initial assert (STAGES >= 2) else $error("xls_sync: STAGES must be at least 2");

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) chain_q <= '0;
      else       chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xls_prescaler.sv
module xls_prescaler #(
   parameter int DIV_W = xls_pkg::XLS_DEF_DIV_W
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             stb_o
);
   initial assert (DIV_W >= 1) else $error("xls_prescaler: DIV_W must be positive");

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim_q;
   logic             stb_q;
   logic             wrap;

   assign wrap = (cnt_q == lim_q);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_q <= '0;
         lim_q <= '0;
         stb_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         lim_q <= div_i;
         stb_q <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         stb_q <= 1'b0;
      end
   end

   assign stb_o = stb_q;

   AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= lim_q);                                          // R2
   AST_LIM_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !wrap |=> $stable(lim_q));                                // R3
endmodule

// File: rtl/xls_delay_line.sv
module xls_delay_line #(
   parameter int TAPS = xls_pkg::XLS_DEF_TAPS
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic shift_i,
   input  logic din_i,
   output logic tail_o
);
   initial assert (TAPS >= 1) else $error("xls_delay_line: TAPS must be positive");

   generate
      if (TAPS == 1) begin : g_single
         logic bit_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)        bit_q <= 1'b0;
            else if (shift_i) bit_q <= din_i;
         end
         assign tail_o = bit_q;
      end else begin : g_chain
         logic [TAPS-1:0] line_q;
         always_ff @(posedge clk_i) begin
            if (rst_i)        line_q <= '0;
            else if (shift_i) line_q <= {line_q[TAPS-2:0], din_i};
         end
         assign tail_o = line_q[TAPS-1];
      end
   endgenerate
endmodule

// File: rtl/xls_stabilizer.sv
module xls_stabilizer #(
   parameter int N     = xls_pkg::XLS_DEF_TAPS,
   parameter int DIV_W = xls_pkg::XLS_DEF_DIV_W
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             osc_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             corr_o,
   output logic             stb_o
);
   initial assert (N >= 1) else $error("xls_stabilizer: N must be positive");  // R9

   logic osc_s;
   logic stb;
   logic tail;
   logic corr_q;

   xls_sync #(.STAGES(xls_pkg::XLS_SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (osc_i),
      .q_o   (osc_s)
   );

   xls_prescaler #(.DIV_W(DIV_W)) u_presc (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .div_i (div_i),
      .stb_o (stb)
   );

   xls_delay_line #(.TAPS(N)) u_line (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .shift_i (stb),
      .din_i   (osc_s),
      .tail_o  (tail)
   );

   always_ff @(posedge clk_i) begin
      if (rst_i)    corr_q <= 1'b0;
      else if (stb) corr_q <= osc_s ^ tail;
   end

   assign corr_o = corr_q;
   assign stb_o  = stb;

   AST_CORR_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !stb |=> $stable(corr_q));                                // R5
   AST_RESET_CLEAR: assert property (@(posedge clk_i)
      rst_i |=> (corr_o == 1'b0 && stb_o == 1'b0));              // R1
endmodule

// File: tb/xls_stabilizer_tb.sv
`timescale 1ns/1ps

module xls_ref_model #(
   parameter int N     = 16,
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             osc,
   input  logic [DIV_W-1:0] div,
   output logic             m_corr,
   output logic             m_stb
);
   bit q[$];
   bit s1, s2, old;
   int cnt, lim;

   initial begin
      m_corr = 0; m_stb = 0; s1 = 0; s2 = 0; cnt = 0; lim = 0;
   end

   always @(posedge clk) begin
      if (rst) begin
         q.delete();
         for (int i = 0; i < N; i++) q.push_front(1'b0);
         s1 = 0; s2 = 0; cnt = 0; lim = 0; m_stb = 0; m_corr = 0;
      end else begin
         if (m_stb) begin
            old = q.pop_back();
            q.push_front(s2);
            m_corr = s2 ^ old;
         end
         s2 = s1;
         s1 = osc;
         if (cnt == lim) begin
            cnt = 0; lim = int'(div); m_stb = 1;
         end else begin
            cnt++; m_stb = 0;
         end
      end
   end
endmodule

module xls_stabilizer_tb;
   localparam int N     = 16;
   localparam int DIV_W = 8;

   logic clk = 0;
   logic rst = 1;
   logic osc = 0;
   logic [DIV_W-1:0] div = 8'd3;
   logic corr, stb, corr1, stb1;
   logic m_corr, m_stb, m_corr1, m_stb1;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;
   int half = 4;
   bit done = 0;
   bit prev_stb = 0;
   bit prev_corr = 0;

   always #2.5 clk = ~clk;

   xls_stabilizer #(.N(N), .DIV_W(DIV_W)) u_dut (
      .clk_i(clk), .rst_i(rst), .osc_i(osc), .div_i(div), .corr_o(corr), .stb_o(stb));
   xls_stabilizer #(.N(1), .DIV_W(DIV_W)) u_dut_n1 (
      .clk_i(clk), .rst_i(rst), .osc_i(osc), .div_i(div), .corr_o(corr1), .stb_o(stb1));

   xls_ref_model #(.N(N), .DIV_W(DIV_W)) u_ref (
      .clk(clk), .rst(rst), .osc(osc), .div(div), .m_corr(m_corr), .m_stb(m_stb));
   xls_ref_model #(.N(1), .DIV_W(DIV_W)) u_ref1 (
      .clk(clk), .rst(rst), .osc(osc), .div(div), .m_corr(m_corr1), .m_stb(m_stb1));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // oscillator square wave and per-cycle comparison with the model
   always @(negedge clk) begin
      cyc++;
      osc <= ((cyc / half) % 2) != 0;
      chk(stb === m_stb,   "R2 strobe vs model",       int'(stb),   int'(m_stb));
      chk(corr === m_corr, "R4 R6 correction vs model", int'(corr),  int'(m_corr));
      chk(stb1 === m_stb1 && corr1 === m_corr1, "R9 N=1 variant vs model",
          int'({stb1, corr1}), int'({m_stb1, m_corr1}));
      if (!rst) chk(corr === prev_corr || prev_stb, "R5 change only after strobe",
                    int'(corr), int'(prev_corr));
      prev_stb  = stb;
      prev_corr = corr;
   end

   task automatic wait_stb();
      do @(negedge clk); while (stb !== 1'b1);
   endtask

   initial begin : main
      int seen0, seen1, t0, t1, t2, t3;
      repeat (3) @(negedge clk);
      chk(corr === 1'b0 && stb === 1'b0, "R1 reset state", int'({corr, stb}), 0);
      @(negedge clk);
      rst = 0;
      @(negedge clk);
      chk(stb === 1'b1, "R2 first strobe after reset", int'(stb), 1);

      // lock point: N*(div+1)=64 cycles, oscillator period 8 cycles
      repeat (150) @(negedge clk);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         chk(corr === 1'b0, "R7 lock point constant zero", int'(corr), 0);
      end

      // offset: oscillator period 10 cycles
      half = 5;
      seen0 = 0; seen1 = 0;
      for (int i = 0; i < 800; i++) begin
         @(negedge clk);
         if (i > 200) begin
            if (corr === 1'b0) seen0++;
            if (corr === 1'b1) seen1++;
         end
      end
      chk(seen0 > 0 && seen1 > 0, "R8 beat shows both levels", seen1, 1);

      // ratio change in the middle of a period
      wait_stb(); t0 = cyc;
      @(negedge clk); div = 8'd6;
      wait_stb(); t1 = cyc;
      wait_stb(); t2 = cyc;
      wait_stb(); t3 = cyc;
      chk(t1 - t0 == 4, "R3 period in progress keeps old ratio", t1 - t0, 4);
      chk(t2 - t1 == 7, "R2 new period length div+1", t2 - t1, 7);
      chk(t3 - t2 == 7, "R2 steady period length", t3 - t2, 7);

      // reset mid-run
      @(negedge clk); rst = 1;
      @(negedge clk);
      chk(corr === 1'b0 && stb === 1'b0, "R1 reset clears outputs", int'({corr, stb}), 0);
      @(negedge clk); rst = 0;
      repeat (200) @(negedge clk);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule